// File: doc/BRIEF.md
# Multiplexed Host Bus Register Port

This block links a host microcontroller to the configuration registers of a video memory controller through eight shared pins and two active-low strobes. The host first places an address on the pins and pulses the address strobe, then places a data byte on the same pins and pulses the write strobe. Both strobes are asynchronous to the block clock. Each passes through a two-stage synchroniser, and the block acts on the falling edge of the synchronised strobe. The host must hold the bus stable for at least four clock cycles after each strobe falls.

The register file contains plain byte registers and a set of 9-bit wide registers. The lower eight bits of each wide register are written at their own addresses. The top bits of all wide registers share one extension byte, together with a few general control bits. A low-byte write goes only to a shadow copy. The visible 9-bit value changes when the extension byte is written later.

One address is reserved as a read request. Sending it as an address arms the port, and the next address/data cycle becomes a read. In that cycle the write strobe acts as an active-low read enable, and the port drives one of two status bytes supplied by surrounding logic.

Top module: `mbp_host_port`

## Requirements
- R1: After reset every register output is zero and the bus output enable is low.
- R2: A falling address strobe stores the bus value as the current address. A falling write strobe, while the address strobe is high, stores the bus value into byte register k when the current address is 0x10+k (k = 0..7). The value appears on `byte_o[8k+7:8k]` no later than three clock edges after the strobe falls.
- R3: A write to address i (i = 0..3) stores the byte in the shadow of wide register i and leaves `wide_o` unchanged.
- R4: A write to address 0x04 (the extension byte) drives data bits 7:4 to `ext_ctl_o` at once. Each wide register i whose low byte was written since its last update then loads {data bit i, shadow byte} onto `wide_o[9i+8:9i]`. Every other wide register keeps its value.
- R5: The address 0x80 arms read mode and does not cause a write. The next address strobe stores the read address. While the write strobe is low in that cycle, `bus_oe_o` is high and `bus_o` returns a byte chosen by the read address: `stat_i[15:8]` for 0x80, `stat_i[7:0]` for 0x81, and zero for any other address.
- R6: Read mode ends when the write strobe rises at the end of the read cycle. After that, `bus_oe_o` is low and the next cycle is an ordinary write.
- R7: No register changes while the port is armed or in the read cycle. This includes the case where the write strobe falls before the read address is sent.
- R8: A write to an address that decodes to no register leaves every output unchanged.
- R9: `bus_oe_o` is never high outside the low phase of the write strobe in an armed read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ale_n_i | input | 1 | Address strobe from host, active low, asynchronous |
| wr_n_i | input | 1 | Data strobe from host, active low; read enable in a read cycle |
| bus_i | input | 8 | Shared address/data pins, as received |
| bus_o | output | 8 | Read data driven toward the host |
| bus_oe_o | output | 1 | Output enable for the shared pins |
| stat_i | input | 16 | Status word from other logic, returned in read cycles |
| wide_o | output | 36 | Four 9-bit wide registers, register i at bits 9i+8:9i |
| ext_ctl_o | output | 4 | General control bits from the upper half of the extension byte |
| byte_o | output | 64 | Eight byte registers, register k at bits 8k+7:8k |

## Verification
The block keeps three pieces of hidden state: the latched address, the pending low-byte flags and the read-mode state. A fault in any of them shows at the ports within one bus cycle. A wrong address or decode sends a byte to the wrong slice of `byte_o`, or to no slice, by the next write. A lost or stuck pending flag shows at the next extension write, when a wide register either fails to take its new low byte or takes an old one. A read-mode state that does not arm or does not clear shows in the very next strobe phase, either as a missing or stray `bus_oe_o` or as a byte written when none should be.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_ARMED = 2'd1,
        PS_READ  = 2'd2
    } port_st_e;

endpackage

// File: rtl/mbp_sync.sv
module mbp_sync #(
    parameter int unsigned N = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] prev_o
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] lvl;
        logic [N-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.meta = raw_i;
        sync_d.lvl  = sync_q.meta;
        sync_d.prev = sync_q.lvl;
    end

    // strobes idle high, so reset to ones
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign lvl_o  = sync_q.lvl;
    assign prev_o = sync_q.prev;

endmodule

// File: rtl/mbp_decode.sv
module mbp_decode #(
    parameter int unsigned DW        = 8,
    parameter int unsigned NUM_WIDE  = 4,
    parameter int unsigned WIDE_BASE = 0,
    parameter int unsigned EXT_ADDR  = 4,
    parameter int unsigned NUM_BYTE  = 8,
    parameter int unsigned BYTE_BASE = 16
) (
    input  logic [DW-1:0]       addr_i,
    output logic [NUM_WIDE-1:0] wide_sel_o,
    output logic                ext_sel_o,
    output logic [NUM_BYTE-1:0] byte_sel_o
);

    for (genvar g = 0; g < NUM_WIDE; g++) begin : g_wide
        assign wide_sel_o[g] = (addr_i == DW'(WIDE_BASE + g));
    end

    for (genvar g = 0; g < NUM_BYTE; g++) begin : g_byte
        assign byte_sel_o[g] = (addr_i == DW'(BYTE_BASE + g));
    end

    assign ext_sel_o = (addr_i == DW'(EXT_ADDR));

endmodule

// File: rtl/mbp_regfile.sv
module mbp_regfile #(
    parameter int unsigned DW       = 8,
    parameter int unsigned NUM_WIDE = 4,
    parameter int unsigned NUM_BYTE = 8
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           we_i,
    input  logic [DW-1:0]                  data_i,
    input  logic [NUM_WIDE-1:0]            wide_sel_i,
    input  logic                           ext_sel_i,
    input  logic [NUM_BYTE-1:0]            byte_sel_i,
    output logic [NUM_WIDE*(DW+1)-1:0]     wide_o,
    output logic [DW-NUM_WIDE-1:0]         ext_ctl_o,
    output logic [NUM_BYTE*DW-1:0]         byte_o
);

    localparam int unsigned WW = DW + 1;
    localparam int unsigned XW = DW - NUM_WIDE;

    typedef struct packed {
        logic [NUM_WIDE-1:0][DW-1:0] shadow;
        logic [NUM_WIDE-1:0]         pend;
        logic [NUM_WIDE-1:0][WW-1:0] wide;
        logic [XW-1:0]               xctl;
        logic [NUM_BYTE-1:0][DW-1:0] bytes;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (we_i) begin
            // low byte of a wide register: shadow only, mark pending
            for (int i = 0; i < NUM_WIDE; i++) begin
                if (wide_sel_i[i]) begin
                    rf_d.shadow[i] = data_i;
                    rf_d.pend[i]   = 1'b1;
                end
            end
            // extension byte: control bits now, commit pending wide values
            if (ext_sel_i) begin
                rf_d.xctl = data_i[DW-1:NUM_WIDE];
                for (int i = 0; i < NUM_WIDE; i++) begin
                    if (rf_q.pend[i]) begin
                        rf_d.wide[i] = {data_i[i], rf_q.shadow[i]};
                        rf_d.pend[i] = 1'b0;
                    end
                end
            end
            for (int k = 0; k < NUM_BYTE; k++) begin
                if (byte_sel_i[k]) begin
                    rf_d.bytes[k] = data_i;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign wide_o    = rf_q.wide;
    assign ext_ctl_o = rf_q.xctl;
    assign byte_o    = rf_q.bytes;

endmodule

// File: rtl/mbp_host_port.sv
module mbp_host_port
    import mbp_pkg::*;
#(
    parameter int unsigned DW        = 8,
    parameter int unsigned NUM_WIDE  = 4,
    parameter int unsigned WIDE_BASE = 8'h00,
    parameter int unsigned EXT_ADDR  = 8'h04,
    parameter int unsigned NUM_BYTE  = 8,
    parameter int unsigned BYTE_BASE = 8'h10,
    parameter int unsigned RD_REQ    = 8'h80,
    parameter int unsigned RD_LO     = 8'h81
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          ale_n_i,
    input  logic                          wr_n_i,
    input  logic [DW-1:0]                 bus_i,
    output logic [DW-1:0]                 bus_o,
    output logic                          bus_oe_o,
    input  logic [2*DW-1:0]               stat_i,
    output logic [NUM_WIDE*(DW+1)-1:0]    wide_o,
    output logic [DW-NUM_WIDE-1:0]        ext_ctl_o,
    output logic [NUM_BYTE*DW-1:0]        byte_o
);

    localparam int unsigned SW = 2 * DW;

    // ---- strobe synchronisation and edge detection ----
    logic [1:0] s_lvl, s_prev;

    mbp_sync #(.N(2)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  ({wr_n_i, ale_n_i}),
        .lvl_o  (s_lvl),
        .prev_o (s_prev)
    );

    logic ale_lvl, ale_fall, wr_lvl, wr_fall, wr_rise;

    assign ale_lvl  = s_lvl[0];
    assign ale_fall = s_prev[0] & ~s_lvl[0];
    assign wr_lvl   = s_lvl[1];
    assign wr_fall  = s_prev[1] & ~s_lvl[1];
    assign wr_rise  = ~s_prev[1] & s_lvl[1];

    // ---- cycle control ----
    typedef struct packed {
        port_st_e      st;
        logic [DW-1:0] addr;
    } ctl_t;

    ctl_t     ctl_d, ctl_q;
    logic     we;
    port_st_e st_q;

    always_comb begin
        ctl_d = ctl_q;
        we    = 1'b0;
        unique case (ctl_q.st)
            PS_IDLE: begin
                if (ale_fall) begin
                    if (bus_i == DW'(RD_REQ)) begin
                        ctl_d.st = PS_ARMED;
                    end else begin
                        ctl_d.addr = bus_i;
                    end
                end else if (wr_fall && ale_lvl) begin
                    we = 1'b1;
                end
            end
            PS_ARMED: begin
                if (ale_fall) begin
                    ctl_d.addr = bus_i;
                    ctl_d.st   = PS_READ;
                end
            end
            PS_READ: begin
                if (ale_fall) begin
                    ctl_d.addr = bus_i;
                end else if (wr_rise) begin
                    ctl_d.st = PS_IDLE;
                end
            end
            default: ctl_d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{st: PS_IDLE, addr: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign st_q = ctl_q.st;

    // ---- read path ----
    logic [DW-1:0] rd_data;

    always_comb begin
        if (ctl_q.addr == DW'(RD_REQ)) begin
            rd_data = stat_i[SW-1:DW];
        end else if (ctl_q.addr == DW'(RD_LO)) begin
            rd_data = stat_i[DW-1:0];
        end else begin
            rd_data = '0;
        end
    end

    assign bus_oe_o = (ctl_q.st == PS_READ) & ~wr_lvl;
    assign bus_o    = bus_oe_o ? rd_data : '0;

    // ---- decode and register storage ----
    logic [NUM_WIDE-1:0] wide_sel;
    logic                ext_sel;
    logic [NUM_BYTE-1:0] byte_sel;

    mbp_decode #(
        .DW        (DW),
        .NUM_WIDE  (NUM_WIDE),
        .WIDE_BASE (WIDE_BASE),
        .EXT_ADDR  (EXT_ADDR),
        .NUM_BYTE  (NUM_BYTE),
        .BYTE_BASE (BYTE_BASE)
    ) i_decode (
        .addr_i     (ctl_q.addr),
        .wide_sel_o (wide_sel),
        .ext_sel_o  (ext_sel),
        .byte_sel_o (byte_sel)
    );

    mbp_regfile #(
        .DW       (DW),
        .NUM_WIDE (NUM_WIDE),
        .NUM_BYTE (NUM_BYTE)
    ) i_regfile (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (we),
        .data_i     (bus_i),
        .wide_sel_i (wide_sel),
        .ext_sel_i  (ext_sel),
        .byte_sel_i (byte_sel),
        .wide_o     (wide_o),
        .ext_ctl_o  (ext_ctl_o),
        .byte_o     (byte_o)
    );

endmodule

// File: rtl/mbp_checker.sv
module mbp_checker
    import mbp_pkg::*;
#(
    parameter int unsigned DW       = 8,
    parameter int unsigned NUM_WIDE = 4,
    parameter int unsigned NUM_BYTE = 8,
    parameter int unsigned RD_REQ   = 8'h80
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       wr_n_i,
    input logic [DW-1:0]              bus_i,
    input logic                       bus_oe_o,
    input logic [NUM_WIDE*(DW+1)-1:0] wide_o,
    input logic [NUM_BYTE*DW-1:0]     byte_o,
    input port_st_e                   st_q,
    input logic                       ale_fall,
    input logic                       wr_rise,
    input logic                       ext_sel,
    input logic                       we
);

    // R9: drive only when the raw write strobe was low two edges earlier
    a_r9_oe_needs_strobe_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_oe_o |-> !$past(wr_n_i, 2));

    // R5: reserved address arms the port
    a_r5_request_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == PS_IDLE && ale_fall && bus_i == DW'(RD_REQ)) |=> (st_q == PS_ARMED));

    // R6: rising read strobe ends read mode
    a_r6_read_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == PS_READ && wr_rise && !ale_fall) |=> (st_q == PS_IDLE));

    // R7: no register change while armed or reading
    a_r7_no_write_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q != PS_IDLE) |=> ($stable(byte_o) && $stable(wide_o)));

    // R4: wide outputs move only after an extension write
    a_r4_wide_on_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(wide_o) |-> $past(ext_sel && we));

endmodule

bind mbp_host_port mbp_checker #(
    .DW       (DW),
    .NUM_WIDE (NUM_WIDE),
    .NUM_BYTE (NUM_BYTE),
    .RD_REQ   (RD_REQ)
) i_mbp_checker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_n_i   (wr_n_i),
    .bus_i    (bus_i),
    .bus_oe_o (bus_oe_o),
    .wide_o   (wide_o),
    .byte_o   (byte_o),
    .st_q     (st_q),
    .ale_fall (ale_fall),
    .wr_rise  (wr_rise),
    .ext_sel  (ext_sel),
    .we       (we)
);

// File: tb/test_mbp_host_port.sv
module test_mbp_host_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  bus = 8'h00;
    logic [15:0] stat = 16'h0000;
    logic [7:0]  bus_o;
    logic        bus_oe;
    logic [35:0] wide_o;
    logic [3:0]  ext_ctl_o;
    logic [63:0] byte_o;

    always #2.5 clk = ~clk;

    mbp_host_port i_mbp_host_port (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .ale_n_i   (ale_n),
        .wr_n_i    (wr_n),
        .bus_i     (bus),
        .bus_o     (bus_o),
        .bus_oe_o  (bus_oe),
        .stat_i    (stat),
        .wide_o    (wide_o),
        .ext_ctl_o (ext_ctl_o),
        .byte_o    (byte_o)
    );

    int compared = 0;
    int mismatched = 0;
    int stray_oe = 0;
    logic rd_window = 1'b0;

    // expected model
    logic [7:0] m_byte [8];
    logic [8:0] m_wide [4];
    logic [7:0] m_shad [4];
    logic [3:0] m_pend = 4'h0;
    logic [3:0] m_x = 4'h0;

    logic [7:0] rd_val;
    logic       rd_oe_in, rd_oe_out;

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        logic [63:0] eb;
        logic [35:0] ew;
        for (int k = 0; k < 8; k++) eb[8*k +: 8] = m_byte[k];
        for (int i = 0; i < 4; i++) ew[9*i +: 9] = m_wide[i];
        chk(req, byte_o, eb);
        chk(req, {28'h0, wide_o}, {28'h0, ew});
        chk(req, {60'h0, ext_ctl_o}, {60'h0, m_x});
    endtask

    task automatic addr_phase(input logic [7:0] a);
        bus = a; ale_n = 1'b0; tick(4);
        ale_n = 1'b1; tick(2);
    endtask

    task automatic data_phase(input logic [7:0] d);
        bus = d; wr_n = 1'b0; tick(4);
        wr_n = 1'b1; tick(4);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        addr_phase(a);
        data_phase(d);
        // model update
        if (a >= 8'h10 && a <= 8'h17) m_byte[a - 8'h10] = d;
        else if (a <= 8'h03) begin m_shad[a[1:0]] = d; m_pend[a[1:0]] = 1'b1; end
        else if (a == 8'h04) begin
            m_x = d[7:4];
            for (int i = 0; i < 4; i++) begin
                if (m_pend[i]) begin m_wide[i] = {d[i], m_shad[i]}; m_pend[i] = 1'b0; end
            end
        end
    endtask

    task automatic bus_read(input logic [7:0] a);
        addr_phase(8'h80);
        addr_phase(a);
        bus = 8'hA5; rd_window = 1'b1; wr_n = 1'b0; tick(4);
        rd_oe_in = bus_oe; rd_val = bus_o;
        wr_n = 1'b1; tick(4);
        rd_window = 1'b0;
        rd_oe_out = bus_oe;
    endtask

    // R9: output enable only in the read strobe window
    always @(negedge clk) begin
        if (rst_n && bus_oe && !rd_window) stray_oe++;
    end

    initial begin
        repeat (200000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        for (int k = 0; k < 8; k++) m_byte[k] = 8'h00;
        for (int i = 0; i < 4; i++) begin m_wide[i] = 9'h000; m_shad[i] = 8'h00; end
        tick(4);
        rst_n = 1'b1;
        tick(3);

        // R1: reset state
        check_all("R1");
        chk("R1 oe", {63'h0, bus_oe}, 64'h0);

        // R2: byte registers, two patterns
        for (int k = 0; k < 8; k++) bus_write(8'h10 + 8'(k), 8'((k * 37 + 5) & 8'hFF));
        check_all("R2 pattern a");
        for (int k = 0; k < 8; k++) bus_write(8'h17 - 8'(k), 8'(~(k * 19)));
        check_all("R2 pattern b");

        // R3: low bytes only reach shadows
        for (int i = 0; i < 4; i++) bus_write(8'(i), 8'(8'h11 * (i + 1)));
        check_all("R3 shadow only");

        // R4: commit with extension byte
        bus_write(8'h04, 8'hA5);
        check_all("R4 first commit");
        bus_write(8'h02, 8'h6C);
        bus_write(8'h04, 8'h3A);
        check_all("R4 single pending");
        bus_write(8'h04, 8'hCF);
        check_all("R4 none pending");
        for (int m = 0; m < 16; m++) begin
            for (int i = 0; i < 4; i++) begin
                if (m[i]) bus_write(8'(i), 8'(m * 16 + i * 3 + 1));
            end
            bus_write(8'h04, {4'(m ^ 5), 4'(~m)});
            check_all("R4 mask sweep");
        end

        // R8: every undecoded address ignored
        for (int a = 0; a < 256; a++) begin
            if (a <= 4 || (a >= 16 && a <= 23) || a == 128) continue;
            addr_phase(8'(a));
            data_phase(8'hFF);
        end
        check_all("R8 undecoded");

        // R5 / R6: status reads
        for (int s = 0; s < 4; s++) begin
            stat = 16'(16'h3C5A * (s + 1) + s);
            bus_read(8'h80);
            chk("R5 hi byte", {56'h0, rd_val}, {48'h0, stat[15:8]});
            chk("R5 oe", {63'h0, rd_oe_in}, 64'h1);
            chk("R6 oe off", {63'h0, rd_oe_out}, 64'h0);
            bus_read(8'h81);
            chk("R5 lo byte", {56'h0, rd_val}, {56'h0, stat[7:0]});
        end

        // R7: read cycle at a byte address writes nothing, returns zero
        bus_read(8'h12);
        chk("R5 other addr", {56'h0, rd_val}, 64'h0);
        check_all("R7 read no write");

        // R6: next cycle is an ordinary write
        bus_write(8'h13, 8'h44);
        check_all("R6 write after read");

        // R7: strobe while armed but before read address is ignored
        addr_phase(8'h80);
        data_phase(8'h99);
        check_all("R7 armed strobe");
        stat = 16'hBEEF;
        addr_phase(8'h81);
        bus = 8'h5A; rd_window = 1'b1; wr_n = 1'b0; tick(4);
        rd_val = bus_o;
        wr_n = 1'b1; tick(4);
        rd_window = 1'b0;
        chk("R5 after armed strobe", {56'h0, rd_val}, 64'hEF);
        check_all("R7 after read");

        chk("R9 stray oe", 64'(stray_oe), 64'h0);
        summary();
    end

endmodule